// File: doc/BRIEF.md
# ADC Readout Word Framer

This block sends one channel's worth of 10-bit converter samples to a readout receiver. On a trigger it walks a sample buffer in ascending order, two samples at a time, and packs each pair into a 32-bit word. Each word also carries the channel number, a 4-bit event count, start and stop markers and an even-parity bit. One word goes out per transfer-clock pulse, together with a data-valid level. A full readout is 128 samples in 64 words.

The transfer clock is made from the system clock. One transfer period is `XFER_DIV` system cycles, and the value must be at least 2. Choosing the divider sets the transfer rate, so a 20 MHz and a 10 MHz link differ only in this parameter. The receiver needs some setup time after valid rises. For that reason the first transfer period after valid rises carries no clock pulse.

The output stream has no back-pressure. The receiver captures on every transfer-clock pulse while valid is high. It cannot stall the sender, so the block has no ready input. The sample buffer is read combinationally: the block drives a pair index and expects both samples of that pair back in the same cycle.

Top module: `adc_word_framer`

## Requirements
- R1: After reset, `xfer_valid_o`, `xfer_clk_o` and `busy_o` are 0 and `xfer_data_o` is all zeros.
- R2: A trigger sampled while idle raises `busy_o` and `xfer_valid_o` in the next cycle. `busy_o` stays high through the whole readout and through the one gap cycle that follows it.
- R3: `xfer_clk_o` is a one-cycle pulse. It stays low for the first `XFER_DIV` cycles of valid. Word k (k = 0..63) is pulsed in cycle 2·`XFER_DIV` + k·`XFER_DIV`, counting the first valid cycle as cycle 1.
- R4: A readout gives exactly 64 clock pulses.
- R5: Word layout, from bit 31 down to bit 0: bit 31 is start; 30:27 is the channel; 26:17 is the even-numbered sample; 16 is parity; 15:12 is the event count; 11:2 is the odd-numbered sample; bit 1 is stop; bit 0 is always 0.
- R6: The start bit is set only in word 0. The stop bit is set only in word 63.
- R7: Bit 16 gives even parity: the XOR of all 32 bits of every word is 0.
- R8: Word k carries sample 2k in the upper field and sample 2k+1 in the lower field. Pair index k on `pair_idx_o` selects those two samples.
- R9: A trigger that arrives while `busy_o` is high has no effect. It does not restart the readout, change the words or extend the readout.
- R10: After the clock pulse of word 63, `xfer_valid_o` drops for one gap cycle with `busy_o` still high. `busy_o` falls in the cycle after that.
- R11: While valid is high, `xfer_data_o` changes only in the cycle that follows a clock pulse.
- R12: The channel and event count are captured when the trigger is accepted. Later changes on `chan_i` and `evcnt_i` do not affect the readout in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Readout request, sampled each cycle |
| chan_i | input | 4 | Channel number for the next readout |
| evcnt_i | input | 4 | Event count for the next readout |
| samp_even_i | input | 10 | Sample 2·`pair_idx_o` from the buffer |
| samp_odd_i | input | 10 | Sample 2·`pair_idx_o`+1 from the buffer |
| pair_idx_o | output | 6 | Sample-pair index read from the buffer |
| xfer_clk_o | output | 1 | Transfer-clock pulse; receiver captures here |
| xfer_valid_o | output | 1 | Data-valid level for the receiver |
| xfer_data_o | output | 32 | Framed word |
| busy_o | output | 1 | Readout in progress |

## Verification
All outputs are registered one edge after the trigger. The bench numbers the cycles from the first negative edge after the edge that accepts a trigger. At that point valid and busy must already be high. The bench also expects each clock pulse exactly 2·`XFER_DIV` + k·`XFER_DIV` cycles in, and it checks the word on the output in that same cycle. The gap cycle must fall one cycle after the last pulse, and busy must be low one cycle later. Triggers placed in the middle of the readout and in the gap cycle are then judged by those same fixed cycle numbers.

// File: rtl/adc_framer_pkg.sv
package adc_framer_pkg;
  localparam int SAMP_W  = 10;
  localparam int CH_W    = 4;
  localparam int EV_W    = 4;
  localparam int WORD_W  = 32;
  localparam int PAR_BIT = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_SEND = 2'd2,
    ST_GAP  = 2'd3
  } xfer_state_e;

  // Build one framed word; parity makes the XOR of all bits zero.
  function automatic logic [WORD_W-1:0] frame_word(
    input logic              first,
    input logic [CH_W-1:0]   ch,
    input logic [SAMP_W-1:0] s_hi,
    input logic [EV_W-1:0]   ev,
    input logic [SAMP_W-1:0] s_lo,
    input logic              last
  );
    logic [WORD_W-1:0] w;
    w = {first, ch, s_hi, 1'b0, ev, s_lo, last, 1'b0};
    w[PAR_BIT] = ^w;
    return w;
  endfunction
endpackage

// File: rtl/adc_xfer_seq.sv
module adc_xfer_seq
  import adc_framer_pkg::*;
#(
  parameter int XFER_DIV = 2,
  parameter int N_WORDS  = 64,
  localparam int IDX_W   = $clog2(N_WORDS),
  localparam int DIV_W   = (XFER_DIV > 1) ? $clog2(XFER_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic             xclk_o,
  output logic             load_o,
  output logic             accept_o,
  output logic             first_o,
  output logic             last_o,
  output logic [IDX_W-1:0] pair_idx_o
);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(XFER_DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_WORDS - 1);

  xfer_state_e      state_q;
  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] idx_q;
  logic             period_end;
  logic             final_word;

  assign period_end = (div_q == DIV_LAST);
  assign final_word = (idx_q == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (trig_i) begin
            state_q <= ST_LEAD;
            div_q   <= '0;
            idx_q   <= '0;
          end
        end
        ST_LEAD: begin
          if (period_end) begin
            div_q   <= '0;
            state_q <= ST_SEND;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        ST_SEND: begin
          if (period_end) begin
            div_q <= '0;
            if (final_word) state_q <= ST_GAP;
            else            idx_q   <= idx_q + 1'b1;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign valid_o    = (state_q == ST_LEAD) || (state_q == ST_SEND);
  assign xclk_o     = (state_q == ST_SEND) && period_end;
  assign accept_o   = (state_q == ST_IDLE) && trig_i;
  assign load_o     = accept_o || (xclk_o && !final_word);
  assign pair_idx_o = (state_q == ST_SEND) ? idx_q + 1'b1 : '0;
  assign first_o    = (pair_idx_o == '0);
  assign last_o     = (pair_idx_o == IDX_LAST);

  // Pulse counter used only by the checks below.
  logic [IDX_W:0] pulse_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pulse_cnt_q <= '0;
    else if (accept_o) pulse_cnt_q <= '0;
    else if (xclk_o)   pulse_cnt_q <= pulse_cnt_q + 1'b1;
  end

  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xclk_o |=> !xclk_o);
  p_lead_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> !xclk_o);
  p_lead_quiet2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |=> !xclk_o);
  p_pulse_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_o) |-> (pulse_cnt_q == (IDX_W+1)'(N_WORDS)));
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && trig_i && idx_q != '0) |=> (idx_q != '0 || !busy_o));
  p_gap_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_o) |-> busy_o);
  p_gap_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_o) |=> (!valid_o && !busy_o));
endmodule

// File: rtl/adc_word_pack.sv
module adc_word_pack
  import adc_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              capture_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [EV_W-1:0]   ev_i,
  input  logic [SAMP_W-1:0] s_hi_i,
  input  logic [SAMP_W-1:0] s_lo_i,
  output logic [WORD_W-1:0] word_o
);
  logic [CH_W-1:0]   ch_q;
  logic [EV_W-1:0]   ev_q;
  logic [CH_W-1:0]   ch_sel;
  logic [EV_W-1:0]   ev_sel;
  logic [WORD_W-1:0] word_q;

  assign ch_sel = capture_i ? ch_i : ch_q;
  assign ev_sel = capture_i ? ev_i : ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      ev_q   <= '0;
      word_q <= '0;
    end else begin
      if (capture_i) begin
        ch_q <= ch_i;
        ev_q <= ev_i;
      end
      if (load_i)
        word_q <= frame_word(first_i, ch_sel, s_hi_i, ev_sel, s_lo_i, last_i);
    end
  end

  assign word_o = word_q;

  p_tag_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !capture_i) |=> (word_o[30:27] == $past(ch_q) && word_o[15:12] == $past(ev_q)));
endmodule

// File: rtl/adc_word_framer.sv
module adc_word_framer
  import adc_framer_pkg::*;
#(
  parameter int XFER_DIV  = 2,
  parameter int N_SAMPLES = 128,
  localparam int N_WORDS  = N_SAMPLES / 2,
  localparam int PAIR_W   = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [EV_W-1:0]   evcnt_i,
  input  logic [SAMP_W-1:0] samp_even_i,
  input  logic [SAMP_W-1:0] samp_odd_i,
  output logic [PAIR_W-1:0] pair_idx_o,
  output logic              xfer_clk_o,
  output logic              xfer_valid_o,
  output logic [WORD_W-1:0] xfer_data_o,
  output logic              busy_o
);
  logic load, accept, first, last;

  adc_xfer_seq #(.XFER_DIV(XFER_DIV), .N_WORDS(N_WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig_i),
    .busy_o    (busy_o),
    .valid_o   (xfer_valid_o),
    .xclk_o    (xfer_clk_o),
    .load_o    (load),
    .accept_o  (accept),
    .first_o   (first),
    .last_o    (last),
    .pair_idx_o(pair_idx_o)
  );

  adc_word_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .capture_i(accept),
    .first_i  (first),
    .last_i   (last),
    .ch_i     (chan_i),
    .ev_i     (evcnt_i),
    .s_hi_i   (samp_even_i),
    .s_lo_i   (samp_odd_i),
    .word_o   (xfer_data_o)
  );

  p_valid_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> busy_o);
  p_even_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> (^xfer_data_o == 1'b0));
  p_marks_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_clk_o |-> !(xfer_data_o[31] && xfer_data_o[1]));
  p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && $past(xfer_valid_o) && !$past(xfer_clk_o)) |-> $stable(xfer_data_o));
endmodule

// File: tb/adc_word_framer_bench.sv
module adc_word_framer_bench;
  localparam int DIV = 2;
  localparam int NW  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_i = 1'b0;
  logic [3:0] chan_i = '0, evcnt_i = '0;
  logic [9:0] samp_even_i, samp_odd_i;
  logic [5:0] pair_idx_o;
  logic xfer_clk_o, xfer_valid_o, busy_o;
  logic [31:0] xfer_data_o;

  int errors = 0;
  int checks = 0;
  int mode_r = 0;
  int seed_r = 0;

  always #4 clk = ~clk;

  adc_word_framer #(.XFER_DIV(DIV)) u_adc_word_framer (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .chan_i(chan_i), .evcnt_i(evcnt_i),
    .samp_even_i(samp_even_i), .samp_odd_i(samp_odd_i), .pair_idx_o(pair_idx_o),
    .xfer_clk_o(xfer_clk_o), .xfer_valid_o(xfer_valid_o), .xfer_data_o(xfer_data_o),
    .busy_o(busy_o)
  );

  function automatic logic [9:0] sval(input int md, input int sd, input int n);
    case (md)
      0:       return 10'((n * 53 + sd * 197 + (n / 8) * 7) % 1024);
      1:       return 10'h3FF;
      2:       return 10'h000;
      default: return (n % 2 == 1) ? 10'h2AA : 10'h155;
    endcase
  endfunction

  assign samp_even_i = sval(mode_r, seed_r, 2 * int'(pair_idx_o));
  assign samp_odd_i  = sval(mode_r, seed_r, 2 * int'(pair_idx_o) + 1);

  function automatic logic [31:0] exp_word(input logic [3:0] ch, input logic [3:0] ev,
                                           input int md, input int sd, input int k);
    logic [31:0] w;
    w = {(k == 0), ch, sval(md, sd, 2 * k), 1'b0, ev, sval(md, sd, 2 * k + 1), (k == NW - 1), 1'b0};
    w[16] = ^w;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run_readout(input logic [3:0] ch, input logic [3:0] ev,
                             input int md, input int sd, input bit disturb);
    int cyc;
    int pulses;
    @(negedge clk);
    chan_i = ch; evcnt_i = ev; mode_r = md; seed_r = sd; trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    chan_i = ~ch; evcnt_i = ~ev;   // R12: late changes must not reach the words
    cyc = 1; pulses = 0;
    check(xfer_valid_o && busy_o, "R2 valid+busy after trigger", {xfer_valid_o, busy_o}, 2'b11);
    while (xfer_valid_o && cyc < 1000) begin
      check(busy_o, "R2 busy during readout", busy_o, 1);
      if (xfer_clk_o) begin
        check(cyc == 2 * DIV + pulses * DIV, "R3 pulse timing", cyc, 2 * DIV + pulses * DIV);
        check(xfer_data_o == exp_word(ch, ev, md, sd, pulses), "R5 R8 R12 word content",
              xfer_data_o, exp_word(ch, ev, md, sd, pulses));
        check(xfer_data_o[31] == (pulses == 0) && xfer_data_o[1] == (pulses == NW - 1),
              "R6 start/stop marks", {xfer_data_o[31], xfer_data_o[1]},
              {(pulses == 0), (pulses == NW - 1)});
        check(^xfer_data_o == 1'b0, "R7 even parity", ^xfer_data_o, 0);
        pulses++;
      end
      if (disturb && cyc == 40) begin
        trig_i = 1'b1; chan_i = 4'h5; evcnt_i = 4'hA;   // R9: ignored while busy
      end else begin
        trig_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    trig_i = 1'b0;
    check(pulses == NW, "R4 pulse count", pulses, NW);
    check(cyc == 2 * DIV + (NW - 1) * DIV + 1, "R10 gap cycle position", cyc, 2 * DIV + (NW - 1) * DIV + 1);
    check(busy_o && !xfer_valid_o, "R10 gap busy high valid low", {busy_o, xfer_valid_o}, 2'b10);
    if (disturb) trig_i = 1'b1;   // R9: trigger in gap cycle is ignored
    @(negedge clk);
    trig_i = 1'b0;
    check(!busy_o, "R10 busy released", busy_o, 0);
    @(negedge clk);
    check(!busy_o && !xfer_valid_o, "R9 no readout from trigger while busy", {busy_o, xfer_valid_o}, 0);
  endtask

  // {chan, ev, mode, seed, disturb}
  localparam logic [18:0] VECS [0:4] = '{
    {4'h3, 4'h9, 2'd0, 8'd1,   1'b0},
    {4'hF, 4'hF, 2'd1, 8'd0,   1'b0},
    {4'h0, 4'h0, 2'd2, 8'd0,   1'b0},
    {4'hA, 4'h5, 2'd3, 8'd0,   1'b1},
    {4'h7, 4'h2, 2'd0, 8'd200, 1'b1}
  };

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!xfer_valid_o && !xfer_clk_o && !busy_o && xfer_data_o == 32'h0, "R1 reset state",
          {xfer_valid_o, xfer_clk_o, busy_o, xfer_data_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !xfer_valid_o, "R1 idle after reset", {busy_o, xfer_valid_o}, 0);
    for (int i = 0; i < 5; i++) begin
      run_readout(VECS[i][18:15], VECS[i][14:11], int'(VECS[i][10:9]), int'(VECS[i][8:1]), VECS[i][0]);
    end
    // Back-to-back readout right after release, with a midway reset
    run_readout(4'h1, 4'hE, 0, 77, 1'b0);
    @(negedge clk);
    chan_i = 4'h2; trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!xfer_valid_o && !busy_o && xfer_data_o == 32'h0, "R1 reset mid-readout",
          {xfer_valid_o, busy_o, xfer_data_o}, 0);
    rst_n = 1'b1;
    run_readout(4'h6, 4'h3, 3, 0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule